// File: doc/BRIEF.md
# Serial Port Register Bank and Interrupt Identifier

This block is the software-facing side of a 16550-style serial port. A host reaches it through a small byte-wide register window that an address selects. The block keeps the control state that the datapath around it consumes: the interrupt enables, the line and modem controls, a scratch byte and a 16-bit baud divisor. It also drives the FIFO control strobes. In the other direction it takes status from the receiver, the transmitter, the modem lines and a busy flag. From these it builds the line and modem status bytes, a prioritised interrupt code, and one interrupt request line.

Offsets 0 and 1 change meaning when the bank-select bit (line control bit 7) is set: they then reach the divisor bytes. Offset 2 returns the interrupt code when read and takes FIFO control when written. An additional status byte at word offset 31 reports the busy flag and the FIFO fill flags. Reading it clears the busy-detect interrupt. That interrupt is raised when software tries to change line control while the port is busy. Read data is combinational in the cycle of the read. A read's side effects take place at the clock edge that ends that cycle.

Top module: `uart_regfile`

## Requirements
- R1: After reset the interrupt enables, line control and modem control read 0, the interrupt code byte reads 0x01 and irq is low.
- R2: Offset 7 is a read/write scratch byte. With line control bit 7 set, offsets 0 and 1 write and read the low and high divisor bytes, and `divisor` shows {high, low}.
- R3: The interrupt enable byte (offset 1, bank bit clear) keeps bits 3:0 (bit 0 receive data/timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem) and reads 0 in bits 7:4.
- R4: Bits 3:0 of the interrupt code byte (offset 2 read) report the highest pending enabled source. The ranking, highest first, is: 0110 line status, then 0111 busy detect, then 1100 character timeout, then 0100 receive data, then 0010 transmit empty, then 0000 modem status. The code is 0001 when nothing is pending. Busy detect needs no enable bit.
- R5: Bits 7:6 of the interrupt code byte read 11 while the FIFOs are enabled and 00 otherwise. Bit 5 reads 1 only while the FIFOs are enabled and the extended FIFO mode is set. Bit 4 reads 0.
- R6: A write to offset 2 sets fifo_en from bit 0, dma_mode from bit 3 and rx_trig from bits 7:6. Bits 1 and 2 give a pulse on rx_fifo_rst and tx_fifo_rst that lasts only for the write cycle. Bit 5 updates ext_fifo only when the bank bit is set.
- R7: The line status byte (offset 5) is {rx_fifo_err, tx_idle, thr_empty, break, framing, parity, overrun, rx_ready}. The four error bits latch pulses on rx_err[3:0] (bit 0 overrun, 1 parity, 2 framing, 3 break). Reading the byte clears them, and with them the line status interrupt.
- R8: A line control write while uart_busy is high leaves line control unchanged and raises busy detect. Reading offset 31 returns {000, rxf_full, rxf_not_empty, txf_empty, txf_not_full, uart_busy} and clears busy detect.
- R9: Transmit-empty becomes pending on a rising edge of thr_empty, or when enable bit 1 is written from 0 to 1 while thr_empty is high. It is cleared by a code-byte read that reports it, or by a write to the transmit data register.
- R10: The modem status byte (offset 6) is {dcd, ri, dsr, cts, dcd changed, ri fell, dsr changed, cts changed}. The four change bits stay set until the byte is read.
- R11: With modem control bit 4 (loopback) set, the modem inputs are taken from the control bits (cts from bit 1, dsr from bit 0, ri from bit 2, dcd from bit 3), and dtr_out, rts_out, aux1_out and aux2_out are held low. Without loopback those pins follow bits 0, 1, 2 and 3.
- R12: irq is high exactly when some enabled source is pending and modem control bit 3 is set.
- R13: A read of offset 0 with the bank bit clear returns rx_data and pulses rx_pop. A write there pulses tx_push with tx_data equal to the written byte, during the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register word offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when rd_en is low |
| rx_data | input | 8 | Head of receive storage |
| rx_ready | input | 1 | Receive data available |
| rx_timeout | input | 1 | Character timeout condition |
| rx_err | input | 4 | Error event pulses: overrun, parity, framing, break |
| rx_fifo_err | input | 1 | An error is held in receive storage |
| thr_empty | input | 1 | Transmit holding storage is empty |
| tx_idle | input | 1 | Transmitter fully empty |
| uart_busy | input | 1 | Port busy flag |
| txf_not_full | input | 1 | Transmit FIFO not full |
| txf_empty | input | 1 | Transmit FIFO empty |
| rxf_not_empty | input | 1 | Receive FIFO not empty |
| rxf_full | input | 1 | Receive FIFO full |
| cts_in | input | 1 | Clear-to-send line |
| dsr_in | input | 1 | Data-set-ready line |
| ri_in | input | 1 | Ring indicator line |
| dcd_in | input | 1 | Carrier detect line |
| rx_pop | output | 1 | Receive data consumed |
| tx_push | output | 1 | Transmit byte written |
| tx_data | output | 8 | Byte to transmit |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control byte |
| dtr_out | output | 1 | DTR pin |
| rts_out | output | 1 | RTS pin |
| aux1_out | output | 1 | Auxiliary output 1 pin |
| aux2_out | output | 1 | Auxiliary output 2 pin |
| loopback | output | 1 | Loopback mode |
| auto_flow | output | 1 | Automatic flow control enable |
| fifo_en | output | 1 | FIFOs enabled |
| rx_fifo_rst | output | 1 | Receive FIFO reset pulse |
| tx_fifo_rst | output | 1 | Transmit FIFO reset pulse |
| dma_mode | output | 1 | DMA mode select |
| ext_fifo | output | 1 | Extended FIFO mode |
| rx_trig | output | 2 | Receive trigger level |
| irq | output | 1 | Interrupt request |

## Verification
The interrupt code is driven by random mixtures of the six sources under random enable masks and random gating. With several sources pending together, each rank of the priority order is compared with the one below it. A masked source that is still pending separates the enable gating from the pending state. Directed sequences cover the ways each source is cleared, and the extended-FIFO bit written with and without the bank bit. Loopback is entered with lines that differ from the pins, so the change bits show that the control bits drive the modem inputs.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'b0000,
    ID_NONE    = 4'b0001,
    ID_TXE     = 4'b0010,
    ID_RXDATA  = 4'b0100,
    ID_LINE    = 4'b0110,
    ID_BUSY    = 4'b0111,
    ID_TIMEOUT = 4'b1100
  } ident_e;

  // enabled pending sources, highest rank first
  typedef struct packed {
    logic line;
    logic busy;
    logic timeout;
    logic rxdata;
    logic txe;
    logic modem;
  } pend_t;

  // decoded access strobes
  typedef struct packed {
    logic rd_rxd;
    logic wr_txd;
    logic wr_div_lo;
    logic wr_div_hi;
    logic wr_ie;
    logic rd_ident;
    logic wr_fctl;
    logic wr_lctl;
    logic wr_mctl;
    logic rd_lstat;
    logic rd_mstat;
    logic wr_scr;
    logic rd_ext;
  } acc_t;

  localparam int unsigned NUM_STD = 8;

  function automatic ident_e pick_ident(input pend_t p);
    if (p.line)         return ID_LINE;
    else if (p.busy)    return ID_BUSY;
    else if (p.timeout) return ID_TIMEOUT;
    else if (p.rxdata)  return ID_RXDATA;
    else if (p.txe)     return ID_TXE;
    else if (p.modem)   return ID_MODEM;
    else                return ID_NONE;
  endfunction

  function automatic logic [7:0] ident_byte(input logic fifo_on, input logic ext_on,
                                            input ident_e code);
    return {fifo_on, fifo_on, fifo_on & ext_on, 1'b0, code};
  endfunction

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned STATUS_OFF = 31
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic               bank,
  output logic [NUM_STD-1:0] sel,
  output logic               ext_hit,
  output acc_t               acc
);
  for (genvar g = 0; g < NUM_STD; g++) begin : g_sel
    assign sel[g] = (addr == ADDR_W'(g));
  end
  assign ext_hit = (addr == ADDR_W'(STATUS_OFF));

  always_comb begin
    acc           = '0;
    acc.rd_rxd    = rd_en & sel[0] & ~bank;
    acc.wr_txd    = wr_en & sel[0] & ~bank;
    acc.wr_div_lo = wr_en & sel[0] & bank;
    acc.wr_div_hi = wr_en & sel[1] & bank;
    acc.wr_ie     = wr_en & sel[1] & ~bank;
    acc.rd_ident  = rd_en & sel[2];
    acc.wr_fctl   = wr_en & sel[2];
    acc.wr_lctl   = wr_en & sel[3];
    acc.wr_mctl   = wr_en & sel[4];
    acc.rd_lstat  = rd_en & sel[5];
    acc.rd_mstat  = rd_en & sel[6];
    acc.wr_scr    = wr_en & sel[7];
    acc.rd_ext    = rd_en & ext_hit;
  end
endmodule

// File: rtl/uart_rf_modem.sv
module uart_rf_modem #(
  parameter int unsigned NLINES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [NLINES-1:0] pins,     // {dcd, ri, dsr, cts}
  input  logic [NLINES-1:0] loop_src, // {dcd, ri, dsr, cts} from control bits
  input  logic       loop_on,
  input  logic       clr,
  output logic [7:0] status,
  output logic       delta_any
);
  localparam int unsigned RI_IDX = 2;

  logic [NLINES-1:0] eff, prev_q, delta_q, chg;

  assign eff = loop_on ? loop_src : pins;

  for (genvar g = 0; g < NLINES; g++) begin : g_chg
    if (g == RI_IDX) begin : g_fall
      assign chg[g] = prev_q[g] & ~eff[g];
    end else begin : g_any
      assign chg[g] = prev_q[g] ^ eff[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= eff;
      delta_q <= chg | (delta_q & {NLINES{~clr}});
    end
  end

  assign status    = {eff, delta_q};
  assign delta_any = |delta_q;
endmodule

// File: rtl/uart_rf_intr.sv
module uart_rf_intr
  import uart_rf_pkg::*;
#(
  parameter int unsigned NERR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      ie,
  input  logic            gate,
  input  logic [NERR-1:0] err_evt,
  input  logic            err_clr,
  input  logic            busy_in,
  input  logic            lctl_try,
  input  logic            busy_clr,
  input  logic            thr_empty,
  input  logic            txe_arm,
  input  logic            txd_wr,
  input  logic            ident_rd,
  input  logic            rx_ready,
  input  logic            rx_timeout,
  input  logic            modem_delta,
  output logic [NERR-1:0] err_bits,
  output ident_e          ident,
  output logic            irq,
  output logic            busy_pend,
  output logic            txe_pend,
  output logic            txe_set
);
  logic [NERR-1:0] err_q;
  logic busy_q, thr_q, txe_q, txe_clr;
  pend_t pend;

  assign txe_set = (thr_empty & ~thr_q) | txe_arm;
  assign txe_clr = txd_wr | (ident_rd & (ident == ID_TXE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      busy_q <= 1'b0;
      thr_q  <= 1'b0;
      txe_q  <= 1'b0;
    end else begin
      err_q <= err_evt | (err_q & {NERR{~err_clr}});
      if (lctl_try & busy_in) busy_q <= 1'b1;
      else if (busy_clr)      busy_q <= 1'b0;
      thr_q <= thr_empty;
      if (txe_set)      txe_q <= 1'b1;
      else if (txe_clr) txe_q <= 1'b0;
    end
  end

  always_comb begin
    pend.line    = ie[2] & (|err_q);
    pend.busy    = busy_q;
    pend.timeout = ie[0] & rx_timeout;
    pend.rxdata  = ie[0] & rx_ready;
    pend.txe     = ie[1] & txe_q;
    pend.modem   = ie[3] & modem_delta;
  end

  assign ident     = pick_ident(pend);
  assign irq       = gate & (|pend);
  assign err_bits  = err_q;
  assign busy_pend = busy_q;
  assign txe_pend  = txe_q;
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned STATUS_OFF = 31,
  parameter logic [15:0] DIV_RESET  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        rx_data,
  input  logic              rx_ready,
  input  logic              rx_timeout,
  input  logic [3:0]        rx_err,
  input  logic              rx_fifo_err,
  input  logic              thr_empty,
  input  logic              tx_idle,
  input  logic              uart_busy,
  input  logic              txf_not_full,
  input  logic              txf_empty,
  input  logic              rxf_not_empty,
  input  logic              rxf_full,
  input  logic              cts_in,
  input  logic              dsr_in,
  input  logic              ri_in,
  input  logic              dcd_in,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [7:0]        tx_data,
  output logic [15:0]       divisor,
  output logic [7:0]        line_ctrl,
  output logic              dtr_out,
  output logic              rts_out,
  output logic              aux1_out,
  output logic              aux2_out,
  output logic              loopback,
  output logic              auto_flow,
  output logic              fifo_en,
  output logic              rx_fifo_rst,
  output logic              tx_fifo_rst,
  output logic              dma_mode,
  output logic              ext_fifo,
  output logic [1:0]        rx_trig,
  output logic              irq
);
  localparam int unsigned BANK_BIT = 7;
  localparam int unsigned MC_W     = 6;

  logic [3:0]        ie_q;
  logic [7:0]        lctl_q, scr_q, div_lo_q, div_hi_q;
  logic [MC_W-1:0]   mctl_q;
  logic              fen_q, dma_q, ext_q;
  logic [1:0]        trig_q;
  logic              bank;
  logic [NUM_STD-1:0] sel;
  logic              ext_hit;
  acc_t              acc;
  logic [7:0]        mstat, lstat, xstat;
  logic              modem_delta;
  logic [3:0]        err_bits;
  ident_e            ident;
  logic              busy_pend, txe_pend, txe_set, txe_arm, lctl_try;

  assign bank = lctl_q[BANK_BIT];

  uart_rf_decode #(.ADDR_W(ADDR_W), .STATUS_OFF(STATUS_OFF)) u_dec (
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .bank(bank),
    .sel(sel), .ext_hit(ext_hit), .acc(acc)
  );

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= '0;
      lctl_q   <= '0;
      mctl_q   <= '0;
      scr_q    <= '0;
      div_lo_q <= DIV_RESET[7:0];
      div_hi_q <= DIV_RESET[15:8];
      fen_q    <= 1'b0;
      dma_q    <= 1'b0;
      ext_q    <= 1'b0;
      trig_q   <= '0;
    end else begin
      if (acc.wr_ie)     ie_q     <= wdata[3:0];
      if (lctl_try && !uart_busy) lctl_q <= wdata;
      if (acc.wr_mctl)   mctl_q   <= wdata[MC_W-1:0];
      if (acc.wr_scr)    scr_q    <= wdata;
      if (acc.wr_div_lo) div_lo_q <= wdata;
      if (acc.wr_div_hi) div_hi_q <= wdata;
      if (acc.wr_fctl) begin
        fen_q  <= wdata[0];
        dma_q  <= wdata[3];
        trig_q <= wdata[7:6];
        if (bank) ext_q <= wdata[5];
      end
    end
  end

  assign lctl_try = acc.wr_lctl;
  assign txe_arm  = acc.wr_ie & wdata[1] & ~ie_q[1] & thr_empty;

  uart_rf_modem #(.NLINES(4)) u_modem (
    .clk(clk), .rst_n(rst_n),
    .pins({dcd_in, ri_in, dsr_in, cts_in}),
    .loop_src({mctl_q[3], mctl_q[2], mctl_q[0], mctl_q[1]}),
    .loop_on(mctl_q[4]),
    .clr(acc.rd_mstat),
    .status(mstat),
    .delta_any(modem_delta)
  );

  uart_rf_intr #(.NERR(4)) u_intr (
    .clk(clk), .rst_n(rst_n),
    .ie(ie_q), .gate(mctl_q[3]),
    .err_evt(rx_err), .err_clr(acc.rd_lstat),
    .busy_in(uart_busy), .lctl_try(lctl_try), .busy_clr(acc.rd_ext),
    .thr_empty(thr_empty), .txe_arm(txe_arm), .txd_wr(acc.wr_txd),
    .ident_rd(acc.rd_ident),
    .rx_ready(rx_ready), .rx_timeout(rx_timeout), .modem_delta(modem_delta),
    .err_bits(err_bits), .ident(ident), .irq(irq),
    .busy_pend(busy_pend), .txe_pend(txe_pend), .txe_set(txe_set)
  );

  assign lstat = {rx_fifo_err, tx_idle, thr_empty, err_bits, rx_ready};
  assign xstat = {3'b000, rxf_full, rxf_not_empty, txf_empty, txf_not_full, uart_busy};

  // read mux
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (1'b1)
        sel[0]:  rdata = bank ? div_lo_q : rx_data;
        sel[1]:  rdata = bank ? div_hi_q : {4'b0000, ie_q};
        sel[2]:  rdata = ident_byte(fen_q, ext_q, ident);
        sel[3]:  rdata = lctl_q;
        sel[4]:  rdata = {2'b00, mctl_q};
        sel[5]:  rdata = lstat;
        sel[6]:  rdata = mstat;
        sel[7]:  rdata = scr_q;
        ext_hit: rdata = xstat;
        default: rdata = '0;
      endcase
    end
  end

  assign rx_pop      = acc.rd_rxd;
  assign tx_push     = acc.wr_txd;
  assign tx_data     = wdata;
  assign divisor     = {div_hi_q, div_lo_q};
  assign line_ctrl   = lctl_q;
  assign loopback    = mctl_q[4];
  assign auto_flow   = mctl_q[5];
  assign dtr_out     = mctl_q[0] & ~mctl_q[4];
  assign rts_out     = mctl_q[1] & ~mctl_q[4];
  assign aux1_out    = mctl_q[2] & ~mctl_q[4];
  assign aux2_out    = mctl_q[3] & ~mctl_q[4];
  assign fifo_en     = fen_q;
  assign dma_mode    = dma_q;
  assign ext_fifo    = ext_q;
  assign rx_trig     = trig_q;
  assign rx_fifo_rst = acc.wr_fctl & wdata[1];
  assign tx_fifo_rst = acc.wr_fctl & wdata[2];
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk
  import uart_rf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       gate,
  input ident_e     ident,
  input logic       lctl_try,
  input logic       uart_busy,
  input logic       busy_pend,
  input logic [7:0] line_ctrl,
  input logic       ident_rd,
  input logic       txe_pend,
  input logic       txe_set,
  input logic       wr_en,
  input logic       rx_fifo_rst,
  input logic       tx_fifo_rst
);
  assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gate);

  assert_none_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ident == ID_NONE) |-> !irq);

  assert_busy_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lctl_try && uart_busy) |=> busy_pend);

  assert_linectl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lctl_try && uart_busy) |=> $stable(line_ctrl));

  assert_txe_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_rd && ident == ID_TXE && !txe_set) |=> !txe_pend);

  assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_rst || tx_fifo_rst) |-> wr_en);
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .gate(mctl_q[3]), .ident(ident),
  .lctl_try(lctl_try), .uart_busy(uart_busy), .busy_pend(busy_pend),
  .line_ctrl(line_ctrl), .ident_rd(acc.rd_ident), .txe_pend(txe_pend),
  .txe_set(txe_set), .wr_en(wr_en), .rx_fifo_rst(rx_fifo_rst),
  .tx_fifo_rst(tx_fifo_rst)
);

// File: tb/tb_uart_regfile.sv
`timescale 1ns/1ps
module tb_uart_regfile;
  localparam int AW = 5;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = '0, rdata, rx_data = '0;
  logic rx_ready = 0, rx_timeout = 0, rx_fifo_err = 0, thr_empty = 0, tx_idle = 0;
  logic [3:0] rx_err = '0;
  logic uart_busy = 0, txf_not_full = 0, txf_empty = 0, rxf_not_empty = 0, rxf_full = 0;
  logic cts_in = 0, dsr_in = 0, ri_in = 0, dcd_in = 0;
  logic rx_pop, tx_push, dtr_out, rts_out, aux1_out, aux2_out, loopback, auto_flow;
  logic fifo_en, rx_fifo_rst, tx_fifo_rst, dma_mode, ext_fifo, irq;
  logic [7:0] tx_data, line_ctrl;
  logic [15:0] divisor;
  logic [1:0] rx_trig;

  int checks = 0, errors = 0;
  bit done = 0;
  logic cap_pop, cap_push, cap_rrst, cap_trst;
  logic [7:0] cap_txd, v;

  always #4 clk = ~clk;

  uart_regfile dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .rx_data(rx_data), .rx_ready(rx_ready), .rx_timeout(rx_timeout),
    .rx_err(rx_err), .rx_fifo_err(rx_fifo_err), .thr_empty(thr_empty), .tx_idle(tx_idle),
    .uart_busy(uart_busy), .txf_not_full(txf_not_full), .txf_empty(txf_empty),
    .rxf_not_empty(rxf_not_empty), .rxf_full(rxf_full), .cts_in(cts_in), .dsr_in(dsr_in),
    .ri_in(ri_in), .dcd_in(dcd_in), .rx_pop(rx_pop), .tx_push(tx_push), .tx_data(tx_data),
    .divisor(divisor), .line_ctrl(line_ctrl), .dtr_out(dtr_out), .rts_out(rts_out),
    .aux1_out(aux1_out), .aux2_out(aux2_out), .loopback(loopback), .auto_flow(auto_flow),
    .fifo_en(fifo_en), .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst),
    .dma_mode(dma_mode), .ext_fifo(ext_fifo), .rx_trig(rx_trig), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    #1 cap_push = tx_push; cap_txd = tx_data; cap_rrst = rx_fifo_rst; cap_trst = tx_fifo_rst;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #1 d = rdata; cap_pop = rx_pop;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse_err(input logic [3:0] e);
    @(negedge clk); rx_err = e;
    @(negedge clk); rx_err = '0;
  endtask

  task automatic rise_thr();
    @(negedge clk); thr_empty = 1;
    @(negedge clk); thr_empty = 0;
  endtask

  function automatic logic [3:0] exp_id(input bit ls, bz, to, rdy, tx, ms);
    if (ls) return 4'h6;
    if (bz) return 4'h7;
    if (to) return 4'hC;
    if (rdy) return 4'h4;
    if (tx) return 4'h2;
    if (ms) return 4'h0;
    return 4'h1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk); #1 chk("R1 irq", irq, 0);
    rd(2, v); chk("R1 ident", v, 8'h01);
    rd(1, v); chk("R1 ie", v, 8'h00);
    rd(3, v); chk("R1 linectl", v, 8'h00);
    rd(4, v); chk("R1 modemctl", v, 8'h00);

    // R2 scratch and divisor bank
    wr(7, 8'hA5); rd(7, v); chk("R2 scratch", v, 8'hA5);
    wr(3, 8'h80); wr(0, 8'h34); wr(1, 8'h12);
    chk("R2 divisor", divisor, 16'h1234);
    rd(0, v); chk("R2 div lo", v, 8'h34);
    rd(1, v); chk("R2 div hi", v, 8'h12);
    // R6 extended bit latched with bank set
    wr(2, 8'hE1);
    wr(3, 8'h03);
    chk("R6 ext bank", ext_fifo, 1);
    chk("R6 trig", rx_trig, 2'b11);
    rd(2, v); chk("R5 ident fifo ext", v, 8'hE1);
    // R3
    wr(1, 8'hF0); rd(1, v); chk("R3 ie upper zero", v, 8'h00);
    // R6 pulses, ext kept without bank
    wr(2, 8'h0E);
    chk("R6 rx rst pulse", cap_rrst, 1);
    chk("R6 tx rst pulse", cap_trst, 1);
    @(negedge clk); #1 chk("R6 pulse ends", {rx_fifo_rst, tx_fifo_rst}, 2'b00);
    chk("R6 dma", dma_mode, 1);
    chk("R6 ext ignored no bank", ext_fifo, 1);
    rd(2, v); chk("R5 ident fifo off", v, 8'h01);
    wr(2, 8'h01); rd(2, v); chk("R5 ident fifo on", v, 8'hE1);
    wr(3, 8'h80); wr(2, 8'h00); wr(3, 8'h03);
    chk("R6 ext cleared", ext_fifo, 0);

    // R13 data path
    rx_data = 8'h5A; rx_ready = 1;
    rd(0, v); chk("R13 rx data", v, 8'h5A); chk("R13 rx pop", cap_pop, 1);
    wr(0, 8'h77); chk("R13 tx push", cap_push, 1); chk("R13 tx data", cap_txd, 8'h77);

    // R7 line status
    wr(4, 8'h08); wr(1, 8'h04); tx_idle = 1;
    pulse_err(4'b0101);
    @(negedge clk); #1 chk("R12 irq line", irq, 1);
    rd(2, v); chk("R7 ident line", v[3:0], 4'h6);
    rd(5, v); chk("R7 linestat", v, 8'h4B);
    rd(2, v); chk("R7 cleared", v[3:0], 4'h1);
    @(negedge clk); #1 chk("R12 irq quiet", irq, 0);

    // R8 busy detect
    wr(1, 8'h00);
    uart_busy = 1; wr(3, 8'h1B); txf_not_full = 1; rxf_full = 1;
    rd(3, v); chk("R8 linectl kept", v, 8'h03);
    rd(2, v); chk("R8 ident busy", v[3:0], 4'h7);
    @(negedge clk); #1 chk("R12 irq busy", irq, 1);
    wr(4, 8'h00); @(negedge clk); #1 chk("R12 irq gated", irq, 0);
    rd(31, v); chk("R8 status", v, 8'h13);
    uart_busy = 0;
    rd(2, v); chk("R8 busy cleared", v[3:0], 4'h1);
    wr(4, 8'h08);

    // R9 transmit empty
    wr(1, 8'h02); rise_thr();
    rd(2, v); chk("R9 ident txe", v[3:0], 4'h2);
    rd(2, v); chk("R9 cleared by ident read", v[3:0], 4'h1);
    rise_thr(); wr(0, 8'h11);
    rd(2, v); chk("R9 cleared by data write", v[3:0], 4'h1);
    wr(1, 8'h00); @(negedge clk); thr_empty = 1; wr(0, 8'h00);
    wr(1, 8'h02);
    rd(2, v); chk("R9 armed by enable", v[3:0], 4'h2);
    thr_empty = 0; wr(0, 8'h00);

    // R10 modem
    wr(1, 8'h08);
    @(negedge clk); dsr_in = 1; ri_in = 1;
    @(negedge clk); ri_in = 0;
    @(negedge clk);
    rd(2, v); chk("R10 ident modem", v[3:0], 4'h0);
    rd(6, v); chk("R10 modemstat", v, 8'h26);
    rd(6, v); chk("R10 deltas cleared", v, 8'h20);
    rd(2, v); chk("R10 ident cleared", v[3:0], 4'h1);

    // R11 loopback
    wr(4, 8'h1F);
    chk("R11 pins low", {dtr_out, rts_out, aux1_out, aux2_out}, 4'b0000);
    chk("R11 loop flag", loopback, 1);
    rd(6, v); chk("R11 loop modemstat", v, 8'hF9);
    wr(4, 8'h0F);
    chk("R11 pins follow", {dtr_out, rts_out, aux1_out, aux2_out}, 4'b1111);

    // R4 random priority mix
    for (int i = 0; i < 300; i++) begin
      logic [3:0] ie;
      bit ev_ls, ev_bz, ev_tx, ev_ms, g;
      rd(5, v); rd(6, v); rd(31, v); wr(0, 8'h00);
      rx_ready = 0; rx_timeout = 0;
      ie = 4'($urandom_range(0, 15));
      g = 1'($urandom_range(0, 1));
      ev_ls = 1'($urandom_range(0, 1)); ev_bz = 1'($urandom_range(0, 1));
      ev_tx = 1'($urandom_range(0, 1)); ev_ms = 1'($urandom_range(0, 1));
      wr(1, {4'h0, ie});
      wr(4, g ? 8'h0B : 8'h03);
      if (ev_ls) pulse_err(4'($urandom_range(1, 15)));
      if (ev_bz) begin uart_busy = 1; wr(3, 8'h03); uart_busy = 0; end
      if (ev_tx) rise_thr();
      if (ev_ms) begin @(negedge clk); cts_in = ~cts_in; @(negedge clk); end
      @(negedge clk);
      rx_ready = 1'($urandom_range(0, 1)); rx_timeout = 1'($urandom_range(0, 1));
      #1;
      begin
        logic [3:0] e;
        e = exp_id(ie[2] & ev_ls, ev_bz, ie[0] & rx_timeout, ie[0] & rx_ready,
                   ie[1] & ev_tx, ie[3] & ev_ms);
        chk("R12 irq random", irq, g & (e != 4'h1));
        rd(2, v); chk("R4 ident random", v[3:0], e);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule